// File: doc/BRIEF.md
# Bus Interrupt Status Byte

This block keeps three sticky interrupt status bits for a parallel storage bus controller. It watches the bus reset line, disconnect and selection-timeout events, and received data bytes with their parity bit. Each bit records one kind of event until software reads the status byte. A maskable interrupt request is raised while any enabled bit is set. The block also produces the odd parity bit for bytes the controller sends.

The bus reset line is passed through a two-flop synchronizer, and only its assertion edge is counted. A reset held for a long time therefore posts one event. The disconnect bit depends on the controller's role and on a low-level mode, in which every disconnect is reported. A selection timeout also sets the disconnect bit.

Top module: `bus_irq_status`

## Requirements
- R1: The status byte holds parity error in bit 0, reset received in bit 1 and unexpected disconnect in bit 2. Bits 7..3 read as zero. After reset, all bits are zero and `irq` is low.
- R2: The OR of `bus_rst_line` and `rst_drive` passes through two synchronizing flops. A 0-to-1 edge on it sets bit 1 on the third rising clock edge after the change. A held assertion sets bit 1 only once.
- R3: An assertion of the controller's own `rst_drive` sets bit 1 in the same way as an external reset.
- R4: Bit 0 is set only when `par_chk_en` and `rx_valid` are both high and the 9 bits `{rx_par, rx_data}` hold an even number of ones (odd parity expected).
- R5: `tx_par` always makes `{tx_par, tx_data}` hold an odd number of ones, whatever `par_chk_en` is.
- R6: When `low_level` is low, a `disc_evt` sets bit 2 only if `initiator` is high and `disc_ok` is low. A disconnect in target role, or a legitimate disconnect, leaves bit 2 clear.
- R7: When `low_level` is high, every `disc_evt` sets bit 2, whatever the role and `disc_ok`.
- R8: A `sel_timeout` pulse sets bit 2 in either role.
- R9: Bits are sticky. A `rd_stb` cycle clears them at the next edge, except that an event in the same cycle leaves its bit set.
- R10: `irq` is high exactly when some status bit is set whose enable in `irq_mask` is 1. A `mask_wr` cycle loads `mask_in` at the next edge. After reset, the mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| initiator | input | 1 | 1 = initiator role, 0 = target role |
| low_level | input | 1 | Low-level mode: report every disconnect |
| par_chk_en | input | 1 | Enable receive parity checking |
| bus_rst_line | input | 1 | Raw, asynchronous bus reset line |
| rst_drive | input | 1 | Controller's own assert-reset control |
| disc_evt | input | 1 | One-cycle disconnect event |
| disc_ok | input | 1 | The accompanying disconnect is legitimate |
| sel_timeout | input | 1 | One-cycle selection-timeout event |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received data byte |
| rx_par | input | 1 | Received parity bit |
| tx_data | input | 8 | Byte to be transmitted |
| tx_par | output | 1 | Generated odd parity for `tx_data` |
| rd_stb | input | 1 | Status read; clears the bits at the next edge |
| mask_wr | input | 1 | Load `mask_in` into the interrupt mask |
| mask_in | input | 3 | New interrupt mask |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
A status bit that is wrongly set or left set shows on `status` and `irq` one cycle after the event that caused it. A synchronizer that is too short or too long moves the reset bit off its third-edge position. The bench checks bit 1 both one edge early and on time. A missing edge detector shows as bit 1 coming back after a read while the line is still held. A faulty clear shows as a bit that is still set in the cycle after a read with no event.

// File: rtl/bus_irq_status.sv
module bus_irq_status #(
  parameter int          SYNC     = 2,
  parameter logic [2:0]  MASK_RST = 3'b111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       initiator,
  input  logic       low_level,
  input  logic       par_chk_en,
  input  logic       bus_rst_line,
  input  logic       rst_drive,
  input  logic       disc_evt,
  input  logic       disc_ok,
  input  logic       sel_timeout,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_par,
  input  logic [7:0] tx_data,
  output logic       tx_par,
  input  logic       rd_stb,
  input  logic       mask_wr,
  input  logic [2:0] mask_in,
  output logic [7:0] status,
  output logic       irq
);

  logic [SYNC:0] rsync;
  logic [2:0]    bits, mask, set_now;
  logic          rst_edge, par_bad, disc_hit;

  always_ff @(posedge clk)
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[SYNC-1:0], bus_rst_line | rst_drive};

  assign rst_edge = rsync[SYNC-1] & ~rsync[SYNC];
  assign par_bad  = par_chk_en & rx_valid & ~(^{rx_par, rx_data});
  assign disc_hit = sel_timeout |
                    (disc_evt & (low_level | (initiator & ~disc_ok)));
  assign set_now  = {disc_hit, rst_edge, par_bad};

  always_ff @(posedge clk)
    if (!rst_n)      bits <= '0;
    else if (rd_stb) bits <= set_now;
    else             bits <= bits | set_now;

  always_ff @(posedge clk)
    if (!rst_n)       mask <= MASK_RST;
    else if (mask_wr) mask <= mask_in;

  assign status = {5'b0, bits};
  assign irq    = |(bits & mask);
  assign tx_par = ~^tx_data;

  p_par_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(par_chk_en && rx_valid));

  p_disc_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(disc_evt || sel_timeout));

  p_rst_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(rsync[SYNC-1]));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status[2:0] & $past(status[2:0])) == $past(status[2:0])));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !disc_evt && !sel_timeout && !rx_valid && !rst_edge)
      |=> (status == 8'h00));

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:3] == 5'b0);

endmodule

// File: tb/sim_bus_irq_status.sv
`timescale 1ns/1ps
module sim_bus_irq_status;
  logic clk = 0, rst_n = 0;
  logic initiator = 0, low_level = 0, par_chk_en = 0, bus_rst_line = 0, rst_drive = 0;
  logic disc_evt = 0, disc_ok = 0, sel_timeout = 0, rx_valid = 0, rx_par = 0;
  logic [7:0] rx_data = 0, tx_data = 0;
  logic rd_stb = 0, mask_wr = 0;
  logic [2:0] mask_in = 0;
  logic tx_par, irq;
  logic [7:0] status;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_irq_status u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    rd_stb = 1; cyc(); rd_stb = 0;
  endtask

  // {init, ll, pce, disc, ok, selto, rxv, rxpar, rxdata[7:0], exp[2:0]}
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    19'b1_0_0_1_0_0_0_0_00000000_100, // R6 initiator unexpected
    19'b0_0_0_1_0_0_0_0_00000000_000, // R6 target role
    19'b1_0_0_1_1_0_0_0_00000000_000, // R6 legitimate
    19'b0_1_0_1_1_0_0_0_00000000_100, // R7 low-level target legit
    19'b1_1_0_1_1_0_0_0_00000000_100, // R7 low-level initiator legit
    19'b0_0_0_0_0_1_0_0_00000000_100, // R8 timeout in target role
    19'b0_0_1_0_0_0_1_1_00000001_001, // R4 bad parity
    19'b0_0_1_0_0_0_1_0_00000001_000, // R4 good parity
    19'b0_0_0_0_0_0_1_1_00000001_000, // R4 check disabled
    19'b0_0_1_0_0_0_0_1_00000001_000, // R4 not receiving
    19'b1_0_1_1_0_0_1_0_00000000_101  // R4 R6 together
  };

  initial begin
    cyc(3);
    chk(status == 8'h00 && irq == 0, "R1 reset state", {irq, status}, 0);
    rst_n = 1;
    cyc(2);
    chk(status == 8'h00, "R1 after release", status, 0);

    for (int i = 0; i < NV; i++) begin
      clear();
      {initiator, low_level, par_chk_en, disc_evt, disc_ok, sel_timeout,
       rx_valid, rx_par, rx_data} = VEC[i][18:3];
      cyc();
      {disc_evt, disc_ok, sel_timeout, rx_valid, rx_par} = '0;
      initiator = 0; low_level = 0; par_chk_en = 0; rx_data = 0;
      chk(status == {5'b0, VEC[i][2:0]}, $sformatf("R1 R4 R6 R7 R8 vector %0d", i),
          status, {5'b0, VEC[i][2:0]});
    end

    // R2: synchronizer latency and once-per-assertion
    clear();
    bus_rst_line = 1;
    cyc(2);
    chk(status[1] == 0, "R2 not before third edge", status, 0);
    cyc();
    chk(status == 8'h02, "R2 set on third edge", status, 2);
    clear();
    cyc(6);
    chk(status == 8'h00, "R2 held line posts once", status, 0);
    bus_rst_line = 0; cyc(4);
    bus_rst_line = 1; cyc(3);
    chk(status == 8'h02, "R2 new assertion posts again", status, 2);
    bus_rst_line = 0; cyc(4); clear();

    // R3: self-driven reset
    rst_drive = 1; cyc(3);
    chk(status == 8'h02, "R3 own reset drive", status, 2);
    rst_drive = 0; cyc(4); clear();

    // R9: sticky and set-wins-over-read
    sel_timeout = 1; cyc(); sel_timeout = 0;
    cyc(5);
    chk(status == 8'h04, "R9 sticky", status, 4);
    rd_stb = 1; sel_timeout = 1; cyc(); rd_stb = 0; sel_timeout = 0;
    chk(status == 8'h04, "R9 event beats read", status, 4);
    clear();
    chk(status == 8'h00, "R9 read clears", status, 0);

    // R10: mask
    chk(irq == 0, "R10 idle irq low", irq, 0);
    sel_timeout = 1; cyc(); sel_timeout = 0;
    chk(irq == 1, "R10 default mask enables", irq, 1);
    mask_wr = 1; mask_in = 3'b011; cyc(); mask_wr = 0;
    chk(irq == 0 && status == 8'h04, "R10 masked bit", irq, 0);
    mask_wr = 1; mask_in = 3'b100; cyc(); mask_wr = 0;
    chk(irq == 1, "R10 unmasked bit", irq, 1);
    clear();
    chk(irq == 0, "R10 irq drops after read", irq, 0);

    // R5: transmit parity
    for (int j = 0; j < 8; j++) begin
      par_chk_en = j[0];
      tx_data = 8'(j * 37 + 5);
      #1;
      chk(^{tx_par, tx_data} == 1'b1, "R5 odd tx parity", {tx_par, tx_data}, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule